// File: doc/BRIEF.md
# Masked AXI ID Transaction Filter Counter

This block watches the address channels of an AXI port and counts only the transactions whose ID passes a shared, masked ID filter. One filter value serves both directions. The read channel feeds the filtered-read event, code 0x41. The write channel feeds the filtered-write event, code 0x42. Each channel keeps two totals. One is a count of accepted bursts. The other is the number of bytes those bursts move.

A mode input selects how the block counts. In basic mode, only the burst totals advance. In enhanced mode, each accepted burst also adds its byte size to the byte total. That byte total is visible through a second window of register addresses. Software programs the filter through a small register port, and reads the totals through the same port.

The filter register holds the ID in its low half and a compare mask in its high half. The stored mask has inverted polarity compared with a user "ignore" mask, so a 1 selects an ID bit for comparison. Software therefore writes the user value XOR 0xFFFF0000.

Top module: `axi_id_filt_cnt`

## Requirements
- R1: After reset, both burst totals, both byte totals and the filter register are zero, and both hit outputs are low.
- R2: The filter register sits at offset 0x30. Bits 15:0 hold the ID to match and bits 31:16 hold the compare mask. A transaction ID matches when ((id XOR filter_id) AND mask) == 0, so a mask bit of 1 compares that ID bit and a 0 ignores it.
- R3: A transaction is counted once, in the cycle where VALID and READY of its address channel are both high. VALID without READY, or READY without VALID, counts nothing.
- R4: The filtered read burst total reads at offset 0x20 and the filtered write burst total reads at offset 0x24. Each adds one per matching handshake and wraps at CNT_W bits.
- R5: With enh_mode high, each matching handshake adds (LEN+1) << SIZE bytes to that channel's byte total. The byte totals read at 0x30 (read channel) and 0x34 (write channel) and wrap at CNT_W bits.
- R6: With enh_mode low, the byte totals hold their value. A read at 0x30 then returns the filter register, and a read at 0x34 returns zero.
- R7: A filter write applies from the next cycle. A handshake in the same cycle as the write is judged with the old filter, and the write leaves all totals unchanged.
- R8: Writes to any offset other than 0x30 change no register.
- R9: rd_hit (wr_hit) pulses high for exactly the one cycle after a matching read (write) handshake, and is low otherwise.
- R10: Read and write channels are judged against the same filter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_mode | input | 1 | 1: byte counting and byte window enabled |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| ar_valid | input | 1 | Read address VALID |
| ar_ready | input | 1 | Read address READY |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size, log2 bytes |
| aw_valid | input | 1 | Write address VALID |
| aw_ready | input | 1 | Write address READY |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size, log2 bytes |
| rd_hit | output | 1 | Filtered-read event pulse |
| wr_hit | output | 1 | Filtered-write event pulse |

## Verification
A wrong filter value or a bad match decision appears at a hit output one cycle after the handshake it affects. The same error appears at the matching burst total on that same cycle. A stray byte increment, or one that is missing, shows in the byte window at the first read after that cycle. Filter corruption is visible at offset 0x30 in basic mode at once. Because every total only moves forward, an error is never cancelled out and stays visible until reset.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned OFS_W  = 8;
    localparam int unsigned FLD_W  = REG_W / 2;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_RD  = 0;
    localparam int unsigned CH_WR  = 1;

    localparam logic [OFS_W-1:0] OFS_BURST = 8'h20;
    localparam logic [OFS_W-1:0] OFS_BYTE  = 8'h30;
    localparam logic [OFS_W-1:0] OFS_FILT  = 8'h30;

    // filter register: compare mask in the upper half, ID in the lower half
    typedef struct packed {
        logic [FLD_W-1:0] care;
        logic [FLD_W-1:0] id;
    } flt_reg_t;

    function automatic logic [OFS_W-1:0] slot_ofs(logic [OFS_W-1:0] base, int unsigned idx);
        return base + OFS_W'(4 * idx);
    endfunction
endpackage

// File: rtl/afc_id_match.sv
module afc_id_match #(
    parameter int unsigned ID_W = 16
) (
    input  logic [ID_W-1:0] txn_id,
    input  logic [ID_W-1:0] flt_id,
    input  logic [ID_W-1:0] flt_care,
    output logic            id_ok
);
    // a care bit of 1 forces that ID bit to agree; 0 ignores it
    assign id_ok = ((txn_id ^ flt_id) & flt_care) == '0;
endmodule

// File: rtl/afc_chan_acc.sv
module afc_chan_acc #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_fire,
    input  logic              id_ok,
    input  logic              byte_mode,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [SIZE_W-1:0] xfer_size,
    output logic [CNT_W-1:0]  burst_tot,
    output logic [CNT_W-1:0]  byte_tot,
    output logic              hit
);
    localparam int unsigned INC_W = LEN_W + (1 << SIZE_W);

    typedef struct packed {
        logic [CNT_W-1:0] bursts;
        logic [CNT_W-1:0] byte_sum;
        logic             hit;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [INC_W-1:0] beats;
    logic [INC_W-1:0] xfer_bytes;
    logic             counted;

    always_comb begin
        beats      = INC_W'(xfer_len) + INC_W'(1);
        xfer_bytes = beats << xfer_size;
        counted    = xfer_fire && id_ok;
        st_d       = st_q;
        st_d.hit   = counted;
        if (counted) begin
            st_d.bursts = st_q.bursts + CNT_W'(1);
            if (byte_mode) begin
                st_d.byte_sum = st_q.byte_sum + CNT_W'(xfer_bytes);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign burst_tot = st_q.bursts;
    assign byte_tot  = st_q.byte_sum;
    assign hit       = st_q.hit;
endmodule

// File: rtl/axi_id_filt_cnt.sv
module axi_id_filt_cnt
    import afc_pkg::*;
#(
    parameter int unsigned ID_W   = 16,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic [SIZE_W-1:0] ar_size,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [SIZE_W-1:0] aw_size,
    output logic              rd_hit,
    output logic              wr_hit
);
    flt_reg_t flt_d, flt_q;

    logic [NUM_CH-1:0]              ch_fire;
    logic [NUM_CH-1:0]              ch_ok;
    logic [NUM_CH-1:0]              ch_hit;
    logic [NUM_CH-1:0][ID_W-1:0]    ch_id;
    logic [NUM_CH-1:0][LEN_W-1:0]   ch_len;
    logic [NUM_CH-1:0][SIZE_W-1:0]  ch_size;
    logic [NUM_CH-1:0][CNT_W-1:0]   burst_w;
    logic [NUM_CH-1:0][CNT_W-1:0]   bytes_w;

    // ---- filter register ----
    always_comb begin
        flt_d = flt_q;
        if (cfg_wr && cfg_addr == OFS_FILT) begin
            flt_d = flt_reg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    // ---- channel fan-in ----
    assign ch_fire[CH_RD] = ar_valid && ar_ready;
    assign ch_id[CH_RD]   = ar_id;
    assign ch_len[CH_RD]  = ar_len;
    assign ch_size[CH_RD] = ar_size;
    assign ch_fire[CH_WR] = aw_valid && aw_ready;
    assign ch_id[CH_WR]   = aw_id;
    assign ch_len[CH_WR]  = aw_len;
    assign ch_size[CH_WR] = aw_size;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        afc_id_match #(.ID_W(ID_W)) u_match (
            .txn_id   (ch_id[c]),
            .flt_id   (flt_q.id[ID_W-1:0]),
            .flt_care (flt_q.care[ID_W-1:0]),
            .id_ok    (ch_ok[c])
        );

        afc_chan_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .xfer_fire (ch_fire[c]),
            .id_ok     (ch_ok[c]),
            .byte_mode (enh_mode),
            .xfer_len  (ch_len[c]),
            .xfer_size (ch_size[c]),
            .burst_tot (burst_w[c]),
            .byte_tot  (bytes_w[c]),
            .hit       (ch_hit[c])
        );
    end

    assign rd_hit = ch_hit[CH_RD];
    assign wr_hit = ch_hit[CH_WR];

    // ---- read decode: byte window overlays the filter slot in enhanced mode ----
    always_comb begin
        cfg_rdata = '0;
        if (!enh_mode && cfg_addr == OFS_FILT) begin
            cfg_rdata = flt_q;
        end
        for (int unsigned c = 0; c < NUM_CH; c++) begin
            if (cfg_addr == slot_ofs(OFS_BURST, c)) begin
                cfg_rdata = REG_W'(burst_w[c]);
            end
            if (enh_mode && cfg_addr == slot_ofs(OFS_BYTE, c)) begin
                cfg_rdata = REG_W'(bytes_w[c]);
            end
        end
    end
endmodule

// File: rtl/afc_chk.sv
module afc_chk #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enh_mode,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [LEN_W-1:0]  ar_len,
    input logic [SIZE_W-1:0] ar_size,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic              rd_hit,
    input logic              wr_hit,
    input logic [CNT_W-1:0]  rd_cnt,
    input logic [CNT_W-1:0]  rd_byt,
    input logic [31:0]       flt
);
    // R9: a read event only follows a read handshake
    a_r9_rd_hit_src: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> $past(ar_valid && ar_ready));

    // R9: a write event only follows a write handshake
    a_r9_wr_hit_src: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> $past(aw_valid && aw_ready));

    // R3: no read handshake, no change of the read burst total
    a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_valid && ar_ready) |=> $stable(rd_cnt));

    // R4: each read event steps the burst total by one
    a_r4_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_cnt == CNT_W'($past(rd_cnt) + CNT_W'(1)));

    // R5: byte total grows by the burst size in enhanced mode
    a_r5_rd_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && $past(enh_mode)) |->
        rd_byt == CNT_W'($past(rd_byt) + ((CNT_W'($past(ar_len)) + CNT_W'(1)) << $past(ar_size))));

    // R6: byte total frozen in basic mode
    a_r6_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |=> $stable(rd_byt));

    // R8: filter only changes through a write at its own offset
    a_r8_flt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == 8'h30) |=> $stable(flt));
endmodule

bind axi_id_filt_cnt afc_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_afc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enh_mode (enh_mode),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_len   (ar_len),
    .ar_size  (ar_size),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .rd_cnt   (burst_w[0]),
    .rd_byt   (bytes_w[0]),
    .flt      (flt_q)
);

// File: tb/test_axi_id_filt_cnt.sv
module test_axi_id_filt_cnt;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enh_mode;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        ar_valid, ar_ready, aw_valid, aw_ready;
    logic [15:0] ar_id, aw_id;
    logic [7:0]  ar_len, aw_len;
    logic [2:0]  ar_size, aw_size;
    logic        rd_hit, wr_hit;

    int n_run  = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0]         m_flt;
    logic [TB_CNT_W-1:0] m_rc, m_wc, m_rb, m_wb;
    logic                m_rh, m_wh;
    int                  rot = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_id_filt_cnt #(.ID_W(16), .CNT_W(TB_CNT_W), .LEN_W(8), .SIZE_W(3)) i_axi_id_filt_cnt (
        .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
        .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic m_match(logic [15:0] id);
        return ((id ^ m_flt[15:0]) & m_flt[31:16]) == 16'h0;
    endfunction

    function automatic logic [TB_CNT_W-1:0] m_bytes(logic [7:0] len, logic [2:0] size);
        logic [31:0] v;
        v = (32'(len) + 32'd1) << size;
        return v[TB_CNT_W-1:0];
    endfunction

    function automatic logic [31:0] exp_rdata(logic [7:0] a);
        case (a)
            8'h20:   return 32'(m_rc);
            8'h24:   return 32'(m_wc);
            8'h30:   return enh_mode ? 32'(m_rb) : m_flt;
            8'h34:   return enh_mode ? 32'(m_wb) : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(logic [7:0] a);
        if (a == 8'h30 || a == 8'h34) return enh_mode ? "R5" : "R6";
        return "R4";
    endfunction

    task automatic model_edge();
        logic rf, wf;
        rf = ar_valid && ar_ready && m_match(ar_id);
        wf = aw_valid && aw_ready && m_match(aw_id);
        m_rh = rf;
        m_wh = wf;
        if (rf) begin
            m_rc = m_rc + 1'b1;
            if (enh_mode) m_rb = m_rb + m_bytes(ar_len, ar_size);
        end
        if (wf) begin
            m_wc = m_wc + 1'b1;
            if (enh_mode) m_wb = m_wb + m_bytes(aw_len, aw_size);
        end
        if (cfg_wr && cfg_addr == 8'h30) m_flt = cfg_wdata;
    endtask

    // one clock: model update at the edge, compare just after it
    task automatic tick();
        logic [7:0] nxt [4] = '{8'h20, 8'h24, 8'h30, 8'h34};
        @(posedge clk);
        model_edge();
        #1;
        chk("R9", "rd_hit", 32'(rd_hit), 32'(m_rh));
        chk("R9", "wr_hit", 32'(wr_hit), 32'(m_wh));
        chk(tag_for(cfg_addr), "rdata", cfg_rdata, exp_rdata(cfg_addr));
        if (!cfg_wr) begin
            cfg_addr = nxt[rot];
            rot = (rot + 1) % 4;
        end
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, "window", cfg_rdata, exp);
    endtask

    task automatic ar_txn(logic [15:0] id, logic [7:0] len, logic [2:0] size);
        ar_valid = 1'b1; ar_ready = 1'b1; ar_id = id; ar_len = len; ar_size = size;
        tick();
        ar_valid = 1'b0; ar_ready = 1'b0;
    endtask

    task automatic aw_txn(logic [15:0] id, logic [7:0] len, logic [2:0] size);
        aw_valid = 1'b1; aw_ready = 1'b1; aw_id = id; aw_len = len; aw_size = size;
        tick();
        aw_valid = 1'b0; aw_ready = 1'b0;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enh_mode = 1'b0; cfg_wr = 1'b0; cfg_addr = 8'h20; cfg_wdata = '0;
        ar_valid = 0; ar_ready = 0; ar_id = 0; ar_len = 0; ar_size = 0;
        aw_valid = 0; aw_ready = 0; aw_id = 0; aw_len = 0; aw_size = 0;
        m_flt = '0; m_rc = '0; m_wc = '0; m_rb = '0; m_wb = '0; m_rh = 0; m_wh = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1", 8'h20, 32'h0);
        rd_chk("R1", 8'h24, 32'h0);
        rd_chk("R1", 8'h30, 32'h0);
        rd_chk("R1", 8'h34, 32'h0);
        chk("R1", "hits", {30'h0, rd_hit, wr_hit}, 32'h0);

        // R3: half handshakes do not count; zero mask matches all
        ar_valid = 1'b1; ar_id = 16'h1111; tick();
        ar_valid = 1'b0; ar_ready = 1'b1; tick(); ar_ready = 1'b0;
        aw_valid = 1'b1; aw_id = 16'h2222; tick(); aw_valid = 1'b0;
        rd_chk("R3", 8'h20, 32'd0);
        rd_chk("R3", 8'h24, 32'd0);
        repeat (3) ar_txn(16'hBEEF, 8'd0, 3'd0);
        repeat (2) aw_txn(16'h0001, 8'd0, 3'd0);
        rd_chk("R3", 8'h20, 32'd3);
        rd_chk("R3", 8'h24, 32'd2);

        // R2: id 0x00A5, compare only the low byte
        cfg_write(8'h30, 32'h00FF_00A5);
        ar_txn(16'h12A5, 8'd0, 3'd0);
        ar_txn(16'h00A4, 8'd0, 3'd0);
        ar_txn(16'hFFA5, 8'd0, 3'd0);
        ar_txn(16'h5A5A, 8'd0, 3'd0);
        rd_chk("R2", 8'h20, 32'd5);
        // R10: write channel uses the same filter
        aw_txn(16'h77A5, 8'd0, 3'd0);
        aw_txn(16'h00A6, 8'd0, 3'd0);
        rd_chk("R10", 8'h24, 32'd3);

        // R7: write and handshake in the same cycle use the old filter
        cfg_wr = 1'b1; cfg_addr = 8'h30; cfg_wdata = 32'hFFFF_1234;
        ar_valid = 1'b1; ar_ready = 1'b1; ar_id = 16'h00A5;
        tick();
        cfg_wr = 1'b0; ar_valid = 1'b0; ar_ready = 1'b0;
        rd_chk("R7", 8'h20, 32'd6);
        ar_txn(16'h00A5, 8'd0, 3'd0);
        rd_chk("R7", 8'h20, 32'd6);
        ar_txn(16'h1234, 8'd0, 3'd0);
        rd_chk("R7", 8'h20, 32'd7);
        rd_chk("R7", 8'h30, 32'hFFFF_1234);

        // R8: writes elsewhere are ignored
        cfg_write(8'h24, 32'hDEAD_BEEF);
        cfg_write(8'h20, 32'h0000_0000);
        cfg_write(8'h34, 32'h1234_5678);
        rd_chk("R8", 8'h30, 32'hFFFF_1234);
        rd_chk("R8", 8'h20, 32'd7);
        rd_chk("R8", 8'h24, 32'd3);

        // R5: byte accumulation and wrap
        enh_mode = 1'b1;
        ar_txn(16'h1234, 8'd3, 3'd2);
        ar_txn(16'h1234, 8'd0, 3'd0);
        ar_txn(16'h1235, 8'd255, 3'd7);
        repeat (3) aw_txn(16'h1234, 8'd255, 3'd7);
        rd_chk("R5", 8'h30, 32'd17);
        rd_chk("R5", 8'h34, 32'd32768);
        rd_chk("R5", 8'h24, 32'd6);

        // R6: basic mode freezes bytes, 0x30 shows the filter
        enh_mode = 1'b0;
        ar_txn(16'h1234, 8'd7, 3'd3);
        rd_chk("R6", 8'h30, 32'hFFFF_1234);
        rd_chk("R6", 8'h34, 32'h0);
        rd_chk("R6", 8'h20, 32'd10);
        enh_mode = 1'b1;
        rd_chk("R6", 8'h30, 32'd17);
        enh_mode = 1'b0;

        // mixed traffic against the reference model
        cfg_write(8'h30, 32'h0F0F_0A0A);
        for (int i = 0; i < 3000; i++) begin
            enh_mode = 1'($urandom_range(0, 1));
            ar_valid = 1'($urandom_range(0, 1)); ar_ready = 1'($urandom_range(0, 1));
            aw_valid = 1'($urandom_range(0, 1)); aw_ready = 1'($urandom_range(0, 1));
            ar_id = (16'($urandom) & 16'hF5F5) | 16'h0A0A;
            aw_id = (16'($urandom) & 16'hF7F7) | 16'h0808;
            ar_len = 8'($urandom); ar_size = 3'($urandom);
            aw_len = 8'($urandom); aw_size = 3'($urandom);
            if ($urandom_range(0, 99) == 0) begin
                cfg_wr = 1'b1;
                cfg_addr = ($urandom_range(0, 1) == 1) ? 8'h30 : 8'h24;
                cfg_wdata = 32'($urandom) | 32'h0F00_0000;
            end
            tick();
            cfg_wr = 1'b0;
        end
        ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;

        // R4: burst total wraps at the counter width
        enh_mode = 1'b0;
        cfg_write(8'h30, 32'h0000_0000);
        begin
            logic [TB_CNT_W-1:0] start;
            start = m_rc;
            ar_valid = 1'b1; ar_ready = 1'b1; ar_id = 16'h0;
            repeat (1 << TB_CNT_W) tick();
            ar_valid = 1'b0; ar_ready = 1'b0;
            rd_chk("R4", 8'h20, 32'(start));
            ar_txn(16'h4444, 8'd0, 3'd0);
            rd_chk("R4", 8'h20, 32'(TB_CNT_W'(start + 1'b1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule